// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves blocks of words between peripheral devices and memory so that the processor does not have to copy them itself. The processor programs each of four channels with a starting memory address, a word count and a direction. When a device with a programmed channel raises its request line, the controller asks the processor for the bus with a hold request. It waits for the hold acknowledge and then grants the device.

Transfers are fly-by. The data never passes through the controller. In each transfer cycle the controller drives the memory address and asserts a memory strobe together with an I/O strobe, so the device and the memory exchange the word directly. After each word the channel's address steps up by one and its count steps down by one. When the count reaches zero, the channel's terminal-count flag is set, the interrupt line goes high and the bus is handed back. Only one channel owns the bus at a time. Transfers between two devices, or from memory to memory, are not possible.

Top module: `dma_flyby`

## Requirements
- R1: After reset the controller is idle. `hold_req`, `dack`, all four strobes, `tc_flags` and `irq` are low, and `mem_addr` is zero.
- R2: A write with `prog_we` high loads the start address, count and direction of channel `prog_ch`. Such a write is ignored when it targets the channel that currently holds or is requesting the bus.
- R3: A pending request on a channel with a nonzero count raises `hold_req` one cycle later. `hold_req` stays high for the whole transfer. No `dack` or strobe is driven until the cycle after `hold_ack` is seen high.
- R4: When several channels request at once, the lowest-numbered channel is served first. Arbitration happens only while the controller is idle, so a new request never pre-empts a running block.
- R5: During each transfer cycle exactly one `dack` bit is high, the one of the channel being served. Outside transfer cycles `dack` is zero.
- R6: Direction bit 1 (memory to device): each transfer cycle asserts `mem_rd` and `io_wr` together.
- R7: Direction bit 0 (device to memory): each transfer cycle asserts `io_rd` and `mem_wr` together.
- R8: `mem_addr` shows the channel's current address during a transfer cycle and zero otherwise. After each word the address increments by one and the count decrements by one.
- R9: After the word that brings the count to zero, `hold_req` drops and bit n of `tc_flags` is set for channel n. `irq` is high whenever any terminal-count flag is set.
- R10: A cycle with `stat_rd` high clears all terminal-count flags, and therefore `irq`. A flag set in the same cycle stays set.
- R11: If a device drops its request while words remain, the current word completes and the bus is released. Service resumes at the next address when the request returns.
- R12: A request on a channel whose count is zero is ignored and does not raise `hold_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Channel programming strobe |
| prog_ch | input | CHW | Channel to program |
| prog_addr | input | AW | Start memory address |
| prog_count | input | CW | Number of words |
| prog_to_dev | input | 1 | Direction: 1 memory to device, 0 device to memory |
| stat_rd | input | 1 | Status read, clears terminal-count flags |
| tc_flags | output | NCH | Per-channel terminal-count flags |
| irq | output | 1 | Completion interrupt |
| dreq | input | NCH | Device DMA requests |
| dack | output | NCH | Device DMA acknowledges |
| hold_req | output | 1 | Bus hold request to processor |
| hold_ack | input | 1 | Bus hold acknowledge from processor |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The hardest situations to reach are the ones where timing overlaps with a busy channel. These are a higher-priority request that arrives after a lower-priority block has started, a reprogramming write aimed at the channel that owns the bus, and a request withdrawn in the middle of a block. The stimulus starts a five-word block on channel 3. Once the controller is in transfer, it raises channel 1 and writes a new count to channel 3. Separately, it drops channel 1's request after two words and raises it again later. Delays of zero, one and two cycles on the hold acknowledge move these events relative to the handover. Every cycle is compared against a behavioural model.

// File: rtl/dma_flyby.sv
module dma_flyby #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_we,
  input  logic [CHW-1:0] prog_ch,
  input  logic [AW-1:0]  prog_addr,
  input  logic [CW-1:0]  prog_count,
  input  logic           prog_to_dev,
  input  logic           stat_rd,
  output logic [NCH-1:0] tc_flags,
  output logic           irq,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hold_req,
  input  logic           hold_ack,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr
);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} state_t;

  state_t         st_q;
  logic [CHW-1:0] cur_q;
  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] dir_q;
  logic [NCH-1:0] tc_q;

  logic           found;
  logic [CHW-1:0] pick;
  logic           xfer;
  logic           last_word;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (dreq[i] && cnt_q[i] != '0) begin
        found = 1'b1;
        pick  = i[CHW-1:0];
      end
    end
  end

  assign xfer      = (st_q == S_XFER);
  assign last_word = xfer && (cnt_q[cur_q] == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (found) begin
          st_q  <= S_HOLD;
          cur_q <= pick;
        end
        S_HOLD: if (hold_ack) st_q <= S_XFER;
        S_XFER: if (last_word || !dreq[cur_q]) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic owned, wr_ok, step;
    assign owned = (st_q != S_IDLE) && (cur_q == CHW'(c));
    assign wr_ok = prog_we && (prog_ch == CHW'(c)) && !owned;
    assign step  = xfer && (cur_q == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[c] <= '0;
        cnt_q[c]  <= '0;
        dir_q[c]  <= 1'b0;
        tc_q[c]   <= 1'b0;
      end else begin
        if (wr_ok) begin
          addr_q[c] <= prog_addr;
          cnt_q[c]  <= prog_count;
          dir_q[c]  <= prog_to_dev;
        end else if (step) begin
          addr_q[c] <= addr_q[c] + AW'(1);
          cnt_q[c]  <= cnt_q[c] - CW'(1);
        end
        if (step && cnt_q[c] == CW'(1)) tc_q[c] <= 1'b1;
        else if (stat_rd)               tc_q[c] <= 1'b0;
      end
    end
  end

  assign hold_req = (st_q != S_IDLE);
  assign dack     = xfer ? (NCH'(1) << cur_q) : '0;
  assign mem_addr = xfer ? addr_q[cur_q] : '0;
  assign mem_rd   = xfer &&  dir_q[cur_q];
  assign io_wr    = xfer &&  dir_q[cur_q];
  assign io_rd    = xfer && !dir_q[cur_q];
  assign mem_wr   = xfer && !dir_q[cur_q];
  assign tc_flags = tc_q;
  assign irq      = |tc_q;

endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic [NCH-1:0] dack,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr
);

  assert_dack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_dack_needs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> (hold_req && $past(hold_req)));

  assert_no_dack_on_hold_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> (dack == '0));

  assert_strobe_pair_mem_to_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (io_wr && !io_rd && !mem_wr));

  assert_strobe_pair_dev_to_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && !io_wr && !mem_rd));

  assert_strobes_with_dack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) == (dack != '0)));

  assert_addr_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0 && $past(dack) == dack) |-> (mem_addr == $past(mem_addr) + AW'(1)));

endmodule

bind dma_flyby dma_flyby_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/tb_dma_flyby.sv
`timescale 1ns/1ps
module tb_dma_flyby;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [1:0]  prog_ch = '0;
  logic [15:0] prog_addr = '0;
  logic [15:0] prog_count = '0;
  logic        prog_to_dev = 1'b0;
  logic        stat_rd = 1'b0;
  logic [3:0]  tc_flags;
  logic        irq;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        hold_req;
  logic        hold_ack = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;

  dma_flyby dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ack_lat = 0, ack_cnt = 0;

  int m_st = 0, m_cur = 0;
  int m_addr [4];
  int m_cnt  [4];
  int m_dir  [4];
  int m_tc   = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int setb, pick;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_cur = 0; m_tc = 0;
      for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_dir[i] = 0; end
    end else begin
      setb = 0;
      if (m_st == 2 && m_cnt[m_cur] == 1) setb = 1 << m_cur;
      pick = -1;
      for (int i = 3; i >= 0; i--) if (dreq[i] && m_cnt[i] != 0) pick = i;
      if (prog_we && !(m_st != 0 && int'(prog_ch) == m_cur)) begin
        m_addr[prog_ch] = prog_addr; m_cnt[prog_ch] = prog_count; m_dir[prog_ch] = prog_to_dev;
        if (m_st == 2 && int'(prog_ch) == m_cur) ; 
      end
      m_tc = (stat_rd ? 0 : m_tc) | setb;
      if (m_st == 0) begin
        if (pick >= 0) begin m_st = 1; m_cur = pick; end
      end else if (m_st == 1) begin
        if (hold_ack) m_st = 2;
      end else begin
        m_addr[m_cur] = (m_addr[m_cur] + 1) & 16'hffff;
        m_cnt[m_cur]  = m_cnt[m_cur] - 1;
        if (setb != 0 || !dreq[m_cur]) m_st = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int xf;
      xf = (m_st == 2);
      chk("R3 hold_req", hold_req, m_st != 0);
      chk("R5 dack", dack, xf ? (1 << m_cur) : 0);
      chk("R8 mem_addr", mem_addr, xf ? m_addr[m_cur] : 0);
      chk("R6 mem_rd", mem_rd, xf && m_dir[m_cur] == 1);
      chk("R6 io_wr", io_wr, xf && m_dir[m_cur] == 1);
      chk("R7 io_rd", io_rd, xf && m_dir[m_cur] == 0);
      chk("R7 mem_wr", mem_wr, xf && m_dir[m_cur] == 0);
      chk("R9 tc_flags", tc_flags, m_tc);
      chk("R9 irq", irq, m_tc != 0);
    end
    if (hold_req) begin
      hold_ack <= (ack_cnt >= ack_lat);
      ack_cnt++;
    end else begin
      hold_ack <= 1'b0;
      ack_cnt = 0;
    end
  end

  task automatic prog(int ch, int a, int n, int d);
    @(negedge clk);
    prog_we = 1; prog_ch = 2'(ch); prog_addr = 16'(a); prog_count = 16'(n); prog_to_dev = d[0];
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic read_status();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  always @(posedge clk) if (cyc == 50000) begin
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hold_req", hold_req, 0);
    chk("R1 dack", dack, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R1 tc_flags", tc_flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_addr", mem_addr, 0);
    rst_n = 1;

    ack_lat = 1;
    prog(2, 'h100, 3, 1);
    dreq[2] = 1;
    repeat (12) @(negedge clk);
    chk("R9 tc ch2", tc_flags, 4'b0100);
    chk("R9 irq", irq, 1);
    read_status();
    chk("R10 cleared", tc_flags, 0);
    chk("R10 irq low", irq, 0);
    dreq = '0;

    ack_lat = 0;
    prog(0, 'h200, 2, 0);
    prog(3, 'h300, 2, 1);
    dreq = 4'b1001;
    repeat (12) @(negedge clk);
    chk("R4 both done", tc_flags, 4'b1001);
    read_status();
    dreq = '0;

    prog(3, 'h400, 5, 0);
    prog(1, 'h500, 2, 1);
    dreq[3] = 1;
    repeat (4) @(negedge clk);
    dreq[1] = 1;
    prog(3, 'h0, 9, 1);
    repeat (20) @(negedge clk);
    chk("R2 R4 both done", tc_flags, 4'b1010);
    read_status();
    dreq = '0;

    ack_lat = 2;
    prog(1, 'h600, 6, 0);
    dreq[1] = 1;
    repeat (6) @(negedge clk);
    dreq[1] = 0;
    repeat (5) @(negedge clk);
    chk("R11 bus released", hold_req, 0);
    chk("R11 not done", tc_flags, 0);
    dreq[1] = 1;
    repeat (20) @(negedge clk);
    chk("R11 resumed done", tc_flags, 4'b0010);
    read_status();
    dreq = 4'b0100;
    repeat (5) @(negedge clk);
    chk("R12 zero count ignored", hold_req, 0);
    dreq = '0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule